// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer with Capture

This block is a 16-bit timer/counter paired with a 16-bit capture/reload register. It runs in one of three configurations: capture, auto-reload, or baud/clock generation. In auto-reload, a further option makes the count direction follow an external pin. The count source is either a machine-cycle tick, a state-time tick (used only in baud generation), or falling edges on an external count pin. Falling edges are found by sampling the pin once per machine cycle.

A second external pin, the trigger, serves several purposes. Depending on the configuration, its falling edges capture the count, force a reload, or only raise a flag. In up/down mode its level sets the count direction instead. Hardware sets two sticky flags: an overflow flag and an external flag. Software clears them through a byte-wide register interface. The block also emits a one-cycle baud pulse on each rollover in baud mode, and a square-wave clock that toggles on each rollover.

Top module: `tmr16_cap`

## Requirements
- R1: The configuration is baud generation when either baud bit (ctrl bit 4 or bit 5) is 1. Otherwise ctrl bit 2 selects capture (1) or auto-reload (0). With the run bit (ctrl bit 0) at 0 the count does not change on any tick.
- R2: With the count select bit (ctrl bit 1) at 0, the count advances by one on each machine-cycle tick, outside baud mode. In baud mode it advances by one on each state-time tick instead. The other tick has no effect on the count.
- R3: With the count select bit at 1, the count pin is sampled on each machine-cycle tick. The count advances by one only on a tick where the previous sample was 1 and the current pin level is 0.
- R4: In capture mode with the external-enable bit (ctrl bit 3) at 1, a trigger falling edge copies the count value held before that cycle into the reload register and sets the external flag. A count of FFFFH that advances becomes 0000H and sets the overflow flag.
- R5: In auto-reload mode counting up, a count of FFFFH that advances loads the reload value and sets the overflow flag. With the external-enable bit at 1, a trigger falling edge loads the reload value and sets the external flag.
- R6: With the up/down bit (mode bit 1) at 1 in auto-reload mode, a trigger level of 1 counts up and 0 counts down. Stepping down when the count equals the reload value loads FFFFH and sets the overflow flag. Every overflow or underflow toggles the external flag. Trigger falling edges neither set the external flag nor reload.
- R7: In baud mode a rollover reloads the count, leaves the overflow flag untouched, and drives the baud pulse output high for exactly the following cycle. A trigger falling edge with external-enable set sets the external flag without reloading.
- R8: The overflow flag (ctrl bit 7) and the external flag (ctrl bit 6) are cleared by writing 0 to their bit of ctrl. Writing 1 has no effect. A hardware set in the same cycle as a clear leaves the flag at 1.
- R9: After reset, ctrl, mode, count and reload all read 00H, and every output is 0.
- R10: With the clock-out enable (mode bit 0) at 1, the clock output toggles on each overflow or underflow and holds its level otherwise.
- R11: When hardware changes the count in the same cycle as a software write to a count byte, the hardware value wins. A capture wins over a write to a reload byte in the same cycle.
- R12: Register addresses: 0 is ctrl, 1 is mode, 2 and 3 are the count low and high bytes, 4 and 5 are the reload low and high bytes. Read data for an address follows the address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_tick_i | input | 1 | Machine-cycle tick, one clock wide |
| st_tick_i | input | 1 | State-time tick, one clock wide |
| cnt_pin_i | input | 1 | External count pin |
| trig_pin_i | input | 1 | External trigger / direction pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External flag |
| baud_pulse_o | output | 1 | One-cycle pulse per rollover in baud mode |
| clk_out_o | output | 1 | Toggle clock output |

## Verification
The embedded assertions check the following on every cycle:
- a flag never rises without a hardware event, and the overflow flag stays low in baud mode;
- the clock output moves only on a rollover, and a baud pulse follows only a cycle in baud mode;
- a capture loads the pre-update count, and a halted counter with no write holds its value;
- a detected count-pin edge leaves a low sample behind.

The bench scenarios cover what needs a sequence to show:
- down-count underflow to the reload floor and the toggling external flag;
- reload on a trigger edge versus capture;
- write-versus-hardware priority;
- random runs of the up-counting reload timer checked against a bench model.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CHI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RHI  = 3'd5;
  typedef enum logic [1:0] {CFG_CAP, CFG_RLD, CFG_BAUD} cfg_e;
  typedef struct packed {
    logic run;
    logic cnt_sel;
    logic cap_sel;
    logic ext_en;
    logic baud_a;
    logic baud_b;
    logic outen;
    logic dcen;
  } ctl_t;
endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic pin_i,
  output logic fall_o
);
  logic s_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) s_q <= 1'b0;
    else if (smp_i) s_q <= pin_i;

  assign fall_o = smp_i & s_q & ~pin_i;

  assert_fall_leaves_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !s_q);
endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output ctl_t              ctl_o
);
  logic ctrl_we, mode_we;
  assign ctrl_we = we_i && (addr_i == A_CTRL);
  assign mode_we = we_i && (addr_i == A_MODE);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ctl_o <= '0;
    end else begin
      if (ctrl_we) begin
        ctl_o.run     <= wdata_i[0];
        ctl_o.cnt_sel <= wdata_i[1];
        ctl_o.cap_sel <= wdata_i[2];
        ctl_o.ext_en  <= wdata_i[3];
        ctl_o.baud_a  <= wdata_i[4];
        ctl_o.baud_b  <= wdata_i[5];
      end
      if (mode_we) begin
        ctl_o.outen <= wdata_i[0];
        ctl_o.dcen  <= wdata_i[1];
      end
    end

  assert_ctrl_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(ctl_o.run) && $stable(ctl_o.cap_sel));
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic              mc_tick_i,
  input  logic              st_tick_i,
  input  logic              cnt_fall_i,
  input  logic              trig_fall_i,
  input  logic              trig_lvl_i,
  input  logic              cnt_we_lo_i,
  input  logic              cnt_we_hi_i,
  input  logic              rld_we_lo_i,
  input  logic              rld_we_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ovf_clr_i,
  input  logic              ext_clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic              ovf_o,
  output logic              ext_o,
  output logic              baud_pulse_o,
  output logic              clk_out_o
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;
  localparam logic [CNT_W-1:0] ALL1 = '1;

  cfg_e cfg;
  logic step, updown, go_down, roll, ext_evt, cap_evt, hw_cnt;
  logic [CNT_W-1:0] cnt_n, rld_n;
  logic ovf_n, ext_keep, ext_n;

  assign cfg     = (ctl_i.baud_a | ctl_i.baud_b) ? CFG_BAUD : (ctl_i.cap_sel ? CFG_CAP : CFG_RLD);
  assign step    = ctl_i.run & (ctl_i.cnt_sel ? cnt_fall_i
                                : ((cfg == CFG_BAUD) ? st_tick_i : mc_tick_i));
  assign updown  = ctl_i.dcen & (cfg == CFG_RLD);
  assign go_down = updown & ~trig_lvl_i;
  assign roll    = step & (go_down ? (cnt_o == rld_o) : (cnt_o == ALL1));
  assign ext_evt = ctl_i.ext_en & trig_fall_i & ~updown;
  assign cap_evt = ext_evt & (cfg == CFG_CAP);

  always_comb begin
    cnt_n  = cnt_o;
    hw_cnt = 1'b0;
    if (step) begin
      hw_cnt = 1'b1;
      if (go_down)                cnt_n = roll ? ALL1 : cnt_o - 1'b1;
      else if (!roll)             cnt_n = cnt_o + 1'b1;
      else if (cfg == CFG_CAP)    cnt_n = '0;
      else                        cnt_n = rld_o;
    end
    if (ext_evt && cfg == CFG_RLD) begin
      hw_cnt = 1'b1;
      cnt_n  = rld_o;
    end
    if (!hw_cnt) begin
      if (cnt_we_lo_i) cnt_n[BYTE_W-1:0]     = wdata_i;
      if (cnt_we_hi_i) cnt_n[CNT_W-1:BYTE_W] = wdata_i[HI_W-1:0];
    end
  end

  always_comb begin
    rld_n = rld_o;
    if (cap_evt) rld_n = cnt_o;
    else begin
      if (rld_we_lo_i) rld_n[BYTE_W-1:0]     = wdata_i;
      if (rld_we_hi_i) rld_n[CNT_W-1:BYTE_W] = wdata_i[HI_W-1:0];
    end
  end

  assign ovf_n    = (roll & (cfg != CFG_BAUD)) | (ovf_o & ~ovf_clr_i);
  assign ext_keep = ext_o & ~ext_clr_i;
  assign ext_n    = ext_evt | ((roll & updown) ? ~ext_keep : ext_keep);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_o        <= '0;
      rld_o        <= '0;
      ovf_o        <= 1'b0;
      ext_o        <= 1'b0;
      baud_pulse_o <= 1'b0;
      clk_out_o    <= 1'b0;
    end else begin
      cnt_o        <= cnt_n;
      rld_o        <= rld_n;
      ovf_o        <= ovf_n;
      ext_o        <= ext_n;
      baud_pulse_o <= roll & (cfg == CFG_BAUD);
      clk_out_o    <= clk_out_o ^ (roll & ctl_i.outen);
    end

  assert_no_baud_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg == CFG_BAUD && !ovf_o) |=> !ovf_o);
  assert_pulse_after_baud_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_pulse_o |-> $past(cfg == CFG_BAUD));
  assert_no_sw_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && !roll) |=> !ovf_o);
  assert_no_sw_ext_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_o && !ext_evt && !roll) |=> !ext_o);
  assert_capture_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> rld_o == $past(cnt_o));
  assert_halt_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.run && !ext_evt && !cnt_we_lo_i && !cnt_we_hi_i) |=> $stable(cnt_o));
  assert_clk_only_on_roll_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(roll && ctl_i.outen) |=> $stable(clk_out_o));
endmodule

// File: rtl/tmr16_cap.sv
module tmr16_cap
  import tmr16_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mc_tick_i,
  input  logic        st_tick_i,
  input  logic        cnt_pin_i,
  input  logic        trig_pin_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        ovf_flag_o,
  output logic        ext_flag_o,
  output logic        baud_pulse_o,
  output logic        clk_out_o
);
  localparam int unsigned CNT_W = 16;

  ctl_t ctl;
  logic cnt_fall, trig_fall, ctrl_we;
  logic [CNT_W-1:0] cnt, rld;

  tmr16_ctrl u_ctrl (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .ctl_o(ctl)
  );

  tmr16_edge u_cnt_edge (
    .clk_i, .rst_ni, .smp_i(mc_tick_i), .pin_i(cnt_pin_i), .fall_o(cnt_fall)
  );

  tmr16_edge u_trig_edge (
    .clk_i, .rst_ni, .smp_i(mc_tick_i), .pin_i(trig_pin_i), .fall_o(trig_fall)
  );

  assign ctrl_we = reg_we_i && (reg_addr_i == A_CTRL);

  tmr16_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .ctl_i(ctl),
    .mc_tick_i, .st_tick_i,
    .cnt_fall_i(cnt_fall), .trig_fall_i(trig_fall), .trig_lvl_i(trig_pin_i),
    .cnt_we_lo_i(reg_we_i && reg_addr_i == A_CLO),
    .cnt_we_hi_i(reg_we_i && reg_addr_i == A_CHI),
    .rld_we_lo_i(reg_we_i && reg_addr_i == A_RLO),
    .rld_we_hi_i(reg_we_i && reg_addr_i == A_RHI),
    .wdata_i(reg_wdata_i),
    .ovf_clr_i(ctrl_we && !reg_wdata_i[7]),
    .ext_clr_i(ctrl_we && !reg_wdata_i[6]),
    .cnt_o(cnt), .rld_o(rld),
    .ovf_o(ovf_flag_o), .ext_o(ext_flag_o),
    .baud_pulse_o, .clk_out_o
  );

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = {ovf_flag_o, ext_flag_o, ctl.baud_b, ctl.baud_a,
                              ctl.ext_en, ctl.cap_sel, ctl.cnt_sel, ctl.run};
      A_MODE:  reg_rdata_o = {6'b0, ctl.dcen, ctl.outen};
      A_CLO:   reg_rdata_o = cnt[7:0];
      A_CHI:   reg_rdata_o = cnt[15:8];
      A_RLO:   reg_rdata_o = rld[7:0];
      A_RHI:   reg_rdata_o = rld[15:8];
      default: reg_rdata_o = 8'h00;
    endcase
  end
endmodule

// File: tb/sim_tmr16_cap.sv
`timescale 1ns/1ps
module sim_tmr16_cap;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mc = 1'b0, st = 1'b0, cpin = 1'b0, tpin = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wd = 8'h00, rdata;
  logic ovf, ext, bp, cko;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr16_cap u0 (
    .clk_i(clk), .rst_ni(rst_n), .mc_tick_i(mc), .st_tick_i(st),
    .cnt_pin_i(cpin), .trig_pin_i(tpin), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .ovf_flag_o(ovf), .ext_flag_o(ext),
    .baud_pulse_o(bp), .clk_out_o(cko)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic w, input logic [2:0] a, input logic [7:0] d,
                     input logic m, input logic s);
    we = w; addr = a; wd = d; mc = m; st = s;
    @(posedge clk); #1;
    we = 1'b0; mc = 1'b0; st = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    drv(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic tk(input logic m, input logic s);
    drv(1'b0, 3'd0, 8'h00, m, s);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi); v = {hi, lo};
  endtask

  task automatic set16(input logic [2:0] a, input logic [15:0] v);
    wr(a, v[7:0]); wr(a + 3'd1, v[15:8]);
  endtask

  // bench model of the up-counting reload timer: {flag, count}
  function automatic logic [16:0] model_up(input logic [15:0] s, input logic [15:0] r, input int n);
    logic [15:0] c = s;
    logic f = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (c == 16'hFFFF) begin c = r; f = 1'b1; end
      else c = c + 16'd1;
    end
    return {f, c};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R9 reset state
    rd(3'd0, b); chk("R9 ctrl", b, 8'h00);
    rd(3'd1, b); chk("R9 mode", b, 8'h00);
    rd16(3'd2, v); chk("R9 count", v, 16'h0000);
    rd16(3'd4, v); chk("R9 reload", v, 16'h0000);
    chk("R9 outputs", {ovf, ext, bp, cko}, 4'b0000);

    // R2 / R5 up-count reload
    set16(3'd4, 16'h1234); set16(3'd2, 16'hFFFD);
    wr(3'd0, 8'h01);
    tk(1'b0, 1'b1);
    rd16(3'd2, v); chk("R2 state tick ignored", v, 16'hFFFD);
    tk(1'b1, 1'b0); tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R2 machine ticks", v, 16'hFFFF);
    tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R5 overflow reload", v, 16'h1234);
    rd(3'd0, b); chk("R5 R12 ctrl with flag", b, 8'h81);

    // R8 flags
    wr(3'd0, 8'hC1);
    chk("R8 write one keeps", {ovf, ext}, 2'b10);
    wr(3'd0, 8'h01);
    chk("R8 write zero clears", ovf, 1'b0);
    set16(3'd2, 16'hFFFF);
    drv(1'b1, 3'd0, 8'h01, 1'b1, 1'b0);
    chk("R8 set beats clear", ovf, 1'b1);
    wr(3'd0, 8'h01);

    // R1 halt
    wr(3'd0, 8'h00);
    tk(1'b1, 1'b0); tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R1 halted", v, 16'h1234);

    // R11 count write vs tick
    wr(3'd0, 8'h01);
    drv(1'b1, 3'd2, 8'hAA, 1'b1, 1'b0);
    rd16(3'd2, v); chk("R11 tick beats write", v, 16'h1235);
    drv(1'b1, 3'd2, 8'hAA, 1'b0, 1'b0);
    rd16(3'd2, v); chk("R11 write alone", v, 16'h12AA);

    // R4 capture
    wr(3'd0, 8'h0D);
    set16(3'd2, 16'h0100);
    tpin = 1'b1; tk(1'b1, 1'b0);
    tpin = 1'b0; tk(1'b1, 1'b0);
    rd16(3'd4, v); chk("R4 capture value", v, 16'h0101);
    rd16(3'd2, v); chk("R4 count continues", v, 16'h0102);
    chk("R4 ext flag", ext, 1'b1);
    set16(3'd2, 16'hFFFF);
    tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R4 wrap to zero", v, 16'h0000);
    chk("R4 ovf flag", ovf, 1'b1);
    rd16(3'd4, v); chk("R4 R1 capture mode no reload", v, 16'h0101);
    wr(3'd0, 8'h0D);
    tpin = 1'b1; tk(1'b1, 1'b0);
    tpin = 1'b0; drv(1'b1, 3'd4, 8'h55, 1'b1, 1'b0);
    rd16(3'd4, v); chk("R11 capture beats write", v, 16'h0001);
    wr(3'd0, 8'h0D);
    chk("R8 both cleared", {ovf, ext}, 2'b00);

    // R3 counter function
    wr(3'd0, 8'h03);
    set16(3'd2, 16'h0000);
    cpin = 1'b1; tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R3 rising no count", v, 16'h0000);
    cpin = 1'b0; tk(1'b0, 1'b1); tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R3 falling counts", v, 16'h0001);
    tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R3 low level no count", v, 16'h0001);
    cpin = 1'b1; tk(1'b1, 1'b0); cpin = 1'b0; tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R3 second edge", v, 16'h0002);

    // R5 trigger reload
    wr(3'd0, 8'h09);
    set16(3'd4, 16'h4000); set16(3'd2, 16'h0010);
    tpin = 1'b1; tk(1'b1, 1'b0);
    tpin = 1'b0; tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R5 trigger reload", v, 16'h4000);
    chk("R5 ext set ovf clear", {ovf, ext}, 2'b01);
    wr(3'd0, 8'h09);

    // R6 up/down
    wr(3'd1, 8'h02);
    set16(3'd4, 16'h0010); set16(3'd2, 16'h0012);
    tk(1'b1, 1'b0); tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R6 down count", v, 16'h0010);
    tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R6 underflow to ones", v, 16'hFFFF);
    chk("R6 flags after underflow", {ovf, ext}, 2'b11);
    tpin = 1'b1; tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R6 up overflow reload", v, 16'h0010);
    chk("R6 ext toggled back", ext, 1'b0);
    tk(1'b1, 1'b0);
    tpin = 1'b0; tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R6 fall no reload", v, 16'h0010);
    chk("R6 fall no ext", ext, 1'b0);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);

    // R7 baud
    set16(3'd4, 16'hFFFE); set16(3'd2, 16'hFFFE);
    wr(3'd0, 8'h11);
    tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R7 R2 machine tick ignored in baud", v, 16'hFFFE);
    tk(1'b0, 1'b1); tk(1'b0, 1'b1);
    rd16(3'd2, v); chk("R7 baud reload", v, 16'hFFFE);
    chk("R7 pulse high", bp, 1'b1);
    chk("R7 no ovf", ovf, 1'b0);
    tk(1'b0, 1'b0);
    chk("R7 pulse one cycle", bp, 1'b0);
    wr(3'd0, 8'h19);
    set16(3'd2, 16'h1000);
    tpin = 1'b1; tk(1'b1, 1'b0);
    tpin = 1'b0; tk(1'b1, 1'b0);
    rd16(3'd2, v); chk("R7 trigger no reload", v, 16'h1000);
    chk("R7 trigger sets ext", ext, 1'b1);

    // R10 clock out
    wr(3'd1, 8'h01);
    set16(3'd2, 16'hFFFF);
    tk(1'b0, 1'b1);
    chk("R10 toggle high", cko, 1'b1);
    tk(1'b0, 1'b1);
    chk("R10 hold", cko, 1'b1);
    tk(1'b0, 1'b1);
    chk("R10 toggle low", cko, 1'b0);
    wr(3'd1, 8'h00);

    // R2 / R5 random
    wr(3'd0, 8'h01);
    for (int i = 0; i < 20; i++) begin
      logic [15:0] r, s;
      logic [16:0] e;
      int n;
      r = 16'($urandom);
      s = 16'hFFFF - 16'($urandom_range(0, 40));
      n = $urandom_range(0, 60);
      set16(3'd4, r); set16(3'd2, s); wr(3'd0, 8'h01);
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 3) == 0) tk(1'b0, 1'b1);
        tk(1'b1, 1'b0);
      end
      e = model_up(s, r, n);
      rd16(3'd2, v); chk("R5 random count", v, e[15:0]);
      chk("R5 random flag", ovf, e[16]);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule